// File: doc/BRIEF.md
# Asymmetric Dual-Port RAM

A dual-port synchronous memory that offers one block of storage at two widths. The wide port sees 256 bytes and the narrow port sees 512 nibbles. Both views cover the same 2048 bits. The storage is held as an array of 4-bit entries. A wide access therefore spans two neighbouring narrow entries: byte address N covers narrow entry 2N as its upper nibble and narrow entry 2N+1 as its lower nibble.

Each port has an enable, a write enable, an address, write data and registered read data. Both ports are clocked by one shared clock. An enabled read returns the contents as they stood before the edge, on either port. If the two ports write the same nibble on the same edge, the narrow port's value is kept. Typical uses are width conversion and packing, for example a producer that writes bytes while a consumer drains nibbles.

Top module: `asym_dpram`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both `a_rdata` and `b_rdata` read 0.
- R2: A wide write of value V at address N stores V[7:4] in narrow entry 2N and V[3:0] in narrow entry 2N+1. Both entries change on the same edge.
- R3: A narrow write of value D at address M stores D in narrow entry M only. A later wide read of address M>>1 returns that nibble in bits [7:4] when M is even, and in bits [3:0] when M is odd.
- R4: The read data of a port updates one clock edge after that port is sampled with its enable high. It holds its value on every edge where the enable is low.
- R5: When a port writes and reads the same address on the same edge, its read data returns the contents from before the write.
- R6: A write enable is ignored while the port's enable is low. The storage is left unchanged.
- R7: A narrow write leaves the other nibble of the same wide word unchanged.
- R8: If both ports write on one edge and the narrow entry lies inside the wide word, the narrow port's nibble is stored. The wide port's other nibble is still written.
- R9: A read on one port that shares an edge with a write on the other port to the same bits returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low reset of the read data registers |
| a_en | input | 1 | Wide port enable |
| a_we | input | 1 | Wide port write enable |
| a_addr | input | 8 | Wide port byte address |
| a_wdata | input | 8 | Wide port write data |
| a_rdata | output | 8 | Wide port registered read data |
| b_en | input | 1 | Narrow port enable |
| b_we | input | 1 | Narrow port write enable |
| b_addr | input | 9 | Narrow port nibble address |
| b_wdata | input | 4 | Narrow port write data |
| b_rdata | output | 4 | Narrow port registered read data |

## Verification
Every result on this block is due exactly one clock edge after the inputs that cause it. That covers read data after an enabled read and storage updates after a write. The bench drives inputs one time unit after a rising edge. It samples both read outputs one time unit after the next rising edge, so each check sees the effect of exactly one edge. The expected read values are taken from a bench reference array before that edge's writes are applied, which models read-first behaviour on both ports. When a port is disabled, its previous expected value is carried forward.

// File: rtl/asym_dpram.sv
module asym_dpram #(
  parameter int NW  = 4,
  parameter int NAW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            a_en,
  input  logic            a_we,
  input  logic [NAW-2:0]  a_addr,
  input  logic [2*NW-1:0] a_wdata,
  output logic [2*NW-1:0] a_rdata,
  input  logic            b_en,
  input  logic            b_we,
  input  logic [NAW-1:0]  b_addr,
  input  logic [NW-1:0]   b_wdata,
  output logic [NW-1:0]   b_rdata
);
  localparam int DEPTH = 1 << NAW;

  logic [NW-1:0] mem [0:DEPTH-1];

  logic [NAW-1:0] a_hi, a_lo;
  assign a_hi = {a_addr, 1'b0};
  assign a_lo = {a_addr, 1'b1};

  logic a_wr, b_wr;
  assign a_wr = a_en & a_we;
  assign b_wr = b_en & b_we;

  always_ff @(posedge clk) begin
    if (a_wr) begin
      mem[a_hi] <= a_wdata[2*NW-1:NW];
      mem[a_lo] <= a_wdata[NW-1:0];
    end
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) a_rdata <= {mem[a_hi], mem[a_lo]};
      if (b_en) b_rdata <= mem[b_addr];
    end
  end

  assert_wide_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_wr) && !($past(b_wr) && $past(b_addr[NAW-1:1]) == $past(a_addr)))
      |-> {mem[{$past(a_addr), 1'b0}], mem[{$past(a_addr), 1'b1}]} == $past(a_wdata));

  assert_narrow_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(b_wr) |-> mem[$past(b_addr)] == $past(b_wdata));

  assert_a_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_rdata));

  assert_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_rdata));
endmodule

// File: tb/asym_dpram_tb.sv
module asym_dpram_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [7:0] a_addr = 0, a_wdata = 0, a_rdata;
  logic [8:0] b_addr = 0;
  logic [3:0] b_wdata = 0, b_rdata;

  logic [3:0] ref_mem [0:511];
  logic [7:0] exp_a = 0;
  logic [3:0] exp_b = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asym_dpram u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  function automatic logic [7:0] ref_word(input logic [7:0] ad);
    return {ref_mem[{ad, 1'b0}], ref_mem[{ad, 1'b1}]};
  endfunction

  task automatic check_out(input string tag);
    checks++;
    if (a_rdata !== exp_a) begin
      errors++;
      $display("FAIL %s a_rdata actual %h expected %h", tag, a_rdata, exp_a);
    end
    checks++;
    if (b_rdata !== exp_b) begin
      errors++;
      $display("FAIL %s b_rdata actual %h expected %h", tag, b_rdata, exp_b);
    end
  endtask

  task automatic step(input logic ae, input logic aw, input logic [7:0] aa, input logic [7:0] ad,
                      input logic be, input logic bw, input logic [8:0] ba, input logic [3:0] bd,
                      input string tag);
    a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
    b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
    if (ae) exp_a = ref_word(aa);
    if (be) exp_b = ref_mem[ba];
    if (ae && aw) begin
      ref_mem[{aa, 1'b0}] = ad[7:4];
      ref_mem[{aa, 1'b1}] = ad[3:0];
    end
    if (be && bw) ref_mem[ba] = bd;
    @(posedge clk);
    #1;
    check_out(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    a_en = 1; b_en = 1;
    @(posedge clk); #1;
    check_out("R1 during reset");
    rst_n = 1;
    a_en = 0; b_en = 0;
    @(posedge clk); #1;
    check_out("R1 after release");

    // R2: fill through the wide port
    for (int i = 0; i < 256; i++)
      step(1, 1, i[7:0], 8'($urandom), 0, 0, 0, 0, "R2 fill");

    // R2: nibble order seen from the narrow port
    step(1, 1, 8'd3, 8'hA5, 0, 0, 0, 0, "R2 write");
    step(0, 0, 0, 0, 1, 0, 9'd6, 0, "R2 upper nibble");
    step(0, 0, 0, 0, 1, 0, 9'd7, 0, "R2 lower nibble");

    // R3/R7: narrow writes assembled on the wide port
    step(0, 0, 0, 0, 1, 1, 9'd9, 4'hC, "R3 narrow write odd");
    step(1, 0, 8'd4, 0, 0, 0, 0, 0, "R7 R3 wide read odd");
    step(0, 0, 0, 0, 1, 1, 9'd8, 4'h3, "R3 narrow write even");
    step(1, 0, 8'd4, 0, 0, 0, 0, 0, "R7 R3 wide read even");

    // R5: read-first on the same port
    step(1, 1, 8'd20, 8'h5A, 0, 0, 0, 0, "R5 wide write");
    step(1, 1, 8'd20, 8'h69, 0, 0, 0, 0, "R5 wide old value");
    step(0, 0, 0, 0, 1, 1, 9'd41, 4'h2, "R5 narrow write");
    step(0, 0, 0, 0, 1, 1, 9'd41, 4'hE, "R5 narrow old value");

    // R6/R4: write enable ignored while disabled, outputs hold
    step(0, 1, 8'd20, 8'hFF, 0, 1, 9'd41, 4'h0, "R6 R4 disabled writes");
    step(1, 0, 8'd20, 0, 1, 0, 9'd41, 0, "R6 contents unchanged");
    step(0, 0, 8'd99, 0, 0, 0, 9'd300, 0, "R4 hold");

    // R9: cross-port read-first
    step(1, 0, 8'd5, 0, 1, 1, 9'd10, 4'h7, "R9 wide reads old");
    step(1, 1, 8'd5, 8'h3C, 1, 0, 9'd11, 0, "R9 narrow reads old");
    step(1, 0, 8'd5, 0, 1, 0, 9'd10, 0, "R9 after writes");

    // R8: colliding writes, narrow nibble kept
    step(1, 1, 8'd7, 8'h12, 1, 1, 9'd15, 4'hF, "R8 collide low");
    step(1, 1, 8'd8, 8'h34, 1, 1, 9'd16, 4'hD, "R8 collide high");
    step(1, 0, 8'd7, 0, 1, 0, 9'd14, 0, "R8 readback 7");
    step(1, 0, 8'd8, 0, 1, 0, 9'd17, 0, "R8 readback 8");

    // mixed random traffic, collisions included
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra;
      logic [8:0] rb;
      ra = 8'($urandom);
      rb = ($urandom % 4 == 0) ? {ra, 1'($urandom)} : 9'($urandom);
      step(1'($urandom), 1'($urandom), ra, 8'($urandom),
           1'($urandom), 1'($urandom), rb, 4'($urandom), "R2 R3 R4 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule